// File: doc/BRIEF.md
# Prefixed Bit Manipulation Unit

This unit carries out the second page of an 8-bit processor's opcode space. That page holds rotates, shifts, a nibble swap, and single-bit test, clear and set operations. The unit receives the second opcode byte after the prefix has already been fetched elsewhere. It picks one of eight operands: seven working registers, or the byte in memory that the 16-bit pointer input addresses. It produces the new value and the updated flags. For a memory operand it runs its own read, compute and write-back sequence.

The register file, the flag register and the memory port stay outside the unit. The unit returns a result byte with a write strobe and a destination code. It also returns a flag word with its own write strobe, and drives memory read and write strobes. The `acc_short` input selects the short accumulator rotate form. That form always works on the accumulator and always clears Z.

Top module: `bitop_unit`

## Requirements
- R1: Opcode bits 2:0 select the operand: 0..5 are the registers B, C, D, E, H, L in that order, 6 is memory at the pointer, 7 is the accumulator. A register result is written back with `reg_sel` equal to that code, and code 6 never appears with `reg_we`.
- R2: Opcode bits 7:6 select the group (00 rotate/shift, 01 test, 10 clear, 11 set). Bits 5:3 give the bit index n, and the mask is 1 shifted left by n.
- R3: Bit test sets Z when the masked bit is 0, clears N, sets H and passes C through unchanged. It writes neither a register nor memory. The flag word is {Z,N,H,C} on bits 3..0.
- R4: Clear and set write the operand with the masked bit forced to 0 or 1. They never assert `flags_we`.
- R5: Within the rotate/shift group, bits 5:3 select the kind. Kind 0 rotates left circularly (bit 7 goes to bit 0 and to C). Kind 1 rotates right circularly (bit 0 goes to bit 7 and to C). Kind 2 rotates left through carry (old C goes to bit 0, bit 7 goes to C). Kind 3 rotates right through carry (old C goes to bit 7, bit 0 goes to C).
- R6: Kind 4 shifts left, filling with 0 and moving bit 7 to C. Kind 5 shifts right arithmetically, keeping bit 7 and moving bit 0 to C. Kind 7 shifts right logically, filling bit 7 with 0 and moving bit 0 to C.
- R7: Kind 6 exchanges the two nibbles and clears C.
- R8: Every rotate, shift or swap clears N and H and sets Z when the result is zero.
- R9: With `acc_short` high, the operand is the accumulator whatever bits 2:0 say. The group is rotate, the kind comes from bits 4:3 (0..3), and Z is always 0.
- R10: For a register operand, `done`, `reg_we`, `flags_we` and the results appear in the cycle after `start`, for exactly one cycle.
- R11: For a memory operand, `mem_rd` is high for one cycle, one cycle after `start`, with `mem_addr` equal to the pointer. Read data is taken in the following cycle. One cycle after that, `done` rises, together with `mem_wr` and the new byte unless the operation is a test.
- R12: A `start` that arrives while `busy` is high is ignored. It leaves the running sequence unchanged and produces no extra result.
- R13: During reset, `done`, `busy`, `reg_we`, `flags_we`, `mem_rd` and `mem_wr` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation on `opcode` |
| opcode | input | 8 | Second opcode byte |
| acc_short | input | 1 | Short accumulator rotate form |
| regs_in | input | 7*DW | Registers B,C,D,E,H,L,A in byte lanes 0..6 |
| hl | input | AW | Memory pointer for operand code 6 |
| carry_in | input | 1 | Current C flag |
| mem_rdata | input | DW | Memory read data |
| busy | output | 1 | Memory sequence in progress |
| done | output | 1 | Result valid pulse |
| out_data | output | DW | Result byte (register or memory write data) |
| reg_we | output | 1 | Write `out_data` to register `reg_sel` |
| reg_sel | output | 3 | Operand code of the destination |
| flags_we | output | 1 | Write `flags_out` |
| flags_out | output | 4 | New {Z,N,H,C} |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | AW | Memory address |

## Verification
The assertions assume that memory returns the addressed byte on `mem_rdata` in the cycle after `mem_rd`, and that `mem_addr` holds steady until the next operation starts. They also assume that `opcode`, `acc_short` and `carry_in` matter only in the cycle `start` is sampled. `start` itself may arrive at any time. The bench drives `mem_rdata` straight from its model memory, indexed by the held address, so read data is always ready when the unit samples it. The bench changes `carry_in` and the registers only between operations. It also raises `start` deliberately during a memory sequence to confirm that the request is dropped.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

   localparam int OPC_W    = 8;
   localparam int SLOTS    = 8;
   localparam int SEL_W    = $clog2(SLOTS);
   localparam int REG_CNT  = SLOTS - 1;
   localparam logic [SEL_W-1:0] MEM_SLOT = 3'd6;
   localparam logic [SEL_W-1:0] ACC_SLOT = 3'd7;

   localparam int FLAG_W = 4;
   localparam int FZ = 3;
   localparam int FN = 2;
   localparam int FH = 1;
   localparam int FC = 0;

   typedef enum logic [1:0] {
      GRP_SHIFT = 2'b00,
      GRP_TEST  = 2'b01,
      GRP_CLR   = 2'b10,
      GRP_SET   = 2'b11
   } grp_e;

   typedef enum logic [2:0] {
      SK_ROLC = 3'd0,
      SK_RORC = 3'd1,
      SK_ROLT = 3'd2,
      SK_RORT = 3'd3,
      SK_SHL  = 3'd4,
      SK_ASR  = 3'd5,
      SK_NSW  = 3'd6,
      SK_LSR  = 3'd7
   } shk_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_MREAD,
      ST_MEXEC
   } seq_e;

   typedef struct packed {
      grp_e             grp;
      logic [2:0]       field;
      logic [SEL_W-1:0] slot;
      logic             short_a;
   } uop_t;

   function automatic logic grp_writes_data(input grp_e g);
      return g != GRP_TEST;
   endfunction

   function automatic logic grp_writes_flags(input grp_e g);
      return (g == GRP_SHIFT) || (g == GRP_TEST);
   endfunction

endpackage

// File: rtl/bitop_decode.sv
module bitop_decode
   import bitop_pkg::*;
(
   input  logic [OPC_W-1:0] opcode,
   input  logic             acc_short,
   output uop_t             uop
);

   always_comb begin
      if (acc_short) begin
         uop.grp     = GRP_SHIFT;
         uop.field   = {1'b0, opcode[4:3]};
         uop.slot    = ACC_SLOT;
         uop.short_a = 1'b1;
      end else begin
         uop.grp     = grp_e'(opcode[7:6]);
         uop.field   = opcode[5:3];
         uop.slot    = opcode[2:0];
         uop.short_a = 1'b0;
      end
   end

endmodule

// File: rtl/bitop_alu.sv
module bitop_alu
   import bitop_pkg::*;
#(
   parameter int DW = 8
)(
   input  uop_t              uop,
   input  logic [DW-1:0]     operand,
   input  logic              cin,
   output logic [DW-1:0]     res,
   output logic [FLAG_W-1:0] flags
);

   localparam int HALF = DW / 2;

   logic [DW-1:0] mask;
   logic [DW-1:0] shifted;
   logic          sh_c;
   logic          msb;
   logic          lsb;

   assign msb = operand[DW-1];
   assign lsb = operand[0];

   // one-hot bit mask decoded from the index field
   generate
      for (genvar i = 0; i < DW; i++) begin : g_mask
         assign mask[i] = (32'(uop.field) == i);
      end
   endgenerate

   always_comb begin
      shifted = operand;
      sh_c    = 1'b0;
      unique case (shk_e'(uop.field))
         SK_ROLC: begin shifted = {operand[DW-2:0], msb}; sh_c = msb; end
         SK_RORC: begin shifted = {lsb, operand[DW-1:1]}; sh_c = lsb; end
         SK_ROLT: begin shifted = {operand[DW-2:0], cin}; sh_c = msb; end
         SK_RORT: begin shifted = {cin, operand[DW-1:1]}; sh_c = lsb; end
         SK_SHL:  begin shifted = {operand[DW-2:0], 1'b0}; sh_c = msb; end
         SK_ASR:  begin shifted = {msb, operand[DW-1:1]}; sh_c = lsb; end
         SK_NSW:  begin shifted = {operand[HALF-1:0], operand[DW-1:HALF]}; sh_c = 1'b0; end
         SK_LSR:  begin shifted = {1'b0, operand[DW-1:1]}; sh_c = lsb; end
         default: begin shifted = operand; sh_c = 1'b0; end
      endcase
   end

   always_comb begin
      flags = '0;
      res   = operand;
      unique case (uop.grp)
         GRP_SHIFT: begin
            res       = shifted;
            flags[FZ] = !uop.short_a && (shifted == '0);
            flags[FC] = sh_c;
         end
         GRP_TEST: begin
            flags[FZ] = ~|(operand & mask);
            flags[FH] = 1'b1;
            flags[FC] = cin;
         end
         GRP_CLR: res = operand & ~mask;
         GRP_SET: res = operand | mask;
         default: res = operand;
      endcase
   end

endmodule

// File: rtl/bitop_seq.sv
module bitop_seq
   import bitop_pkg::*;
#(
   parameter int DW = 8,
   parameter int AW = 16
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  uop_t              live_uop,
   input  logic              carry_in,
   input  logic [AW-1:0]     hl,
   input  logic [DW-1:0]     alu_res,
   input  logic [FLAG_W-1:0] alu_flags,
   output logic              busy,
   output uop_t              held_uop,
   output logic              held_c,
   output logic              done,
   output logic [DW-1:0]     out_data,
   output logic              reg_we,
   output logic [SEL_W-1:0]  reg_sel,
   output logic              flags_we,
   output logic [FLAG_W-1:0] flags_out,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [AW-1:0]     mem_addr
);

   seq_e state;

   assign busy = (state != ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         held_uop  <= '0;
         held_c    <= 1'b0;
         done      <= 1'b0;
         out_data  <= '0;
         reg_we    <= 1'b0;
         reg_sel   <= '0;
         flags_we  <= 1'b0;
         flags_out <= '0;
         mem_rd    <= 1'b0;
         mem_wr    <= 1'b0;
         mem_addr  <= '0;
      end else begin
         done     <= 1'b0;
         reg_we   <= 1'b0;
         flags_we <= 1'b0;
         mem_rd   <= 1'b0;
         mem_wr   <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  held_uop <= live_uop;
                  held_c   <= carry_in;
                  reg_sel  <= live_uop.slot;
                  if (live_uop.slot == MEM_SLOT) begin
                     state    <= ST_MREAD;
                     mem_rd   <= 1'b1;
                     mem_addr <= hl;
                  end else begin
                     done      <= 1'b1;
                     out_data  <= alu_res;
                     flags_out <= alu_flags;
                     reg_we    <= grp_writes_data(live_uop.grp);
                     flags_we  <= grp_writes_flags(live_uop.grp);
                  end
               end
            end
            ST_MREAD: state <= ST_MEXEC;
            ST_MEXEC: begin
               state     <= ST_IDLE;
               done      <= 1'b1;
               out_data  <= alu_res;
               flags_out <= alu_flags;
               flags_we  <= grp_writes_flags(held_uop.grp);
               mem_wr    <= grp_writes_data(held_uop.grp);
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
   import bitop_pkg::*;
#(
   parameter int DW = 8,
   parameter int AW = 16
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [OPC_W-1:0]     opcode,
   input  logic                 acc_short,
   input  logic [REG_CNT*DW-1:0] regs_in,
   input  logic [AW-1:0]        hl,
   input  logic                 carry_in,
   input  logic [DW-1:0]        mem_rdata,
   output logic                 busy,
   output logic                 done,
   output logic [DW-1:0]        out_data,
   output logic                 reg_we,
   output logic [SEL_W-1:0]     reg_sel,
   output logic                 flags_we,
   output logic [FLAG_W-1:0]    flags_out,
   output logic                 mem_rd,
   output logic                 mem_wr,
   output logic [AW-1:0]        mem_addr
);

   generate
      if (DW < 8 || (DW % 2) != 0) begin : g_bad_dw
         $error("bitop_unit: DW must be even and at least 8");
      end
      if (AW < 1) begin : g_bad_aw
         $error("bitop_unit: AW must be positive");
      end
   endgenerate

   uop_t              live_uop;
   uop_t              held_uop;
   uop_t              alu_uop;
   logic              held_c;
   logic              alu_cin;
   logic [DW-1:0]     alu_operand;
   logic [DW-1:0]     alu_res;
   logic [FLAG_W-1:0] alu_flags;
   logic [DW-1:0]     slot_val [SLOTS];

   // operand slots: registers in lanes, memory data on the memory code
   generate
      for (genvar g = 0; g < SLOTS; g++) begin : g_slot
         if (g == int'(MEM_SLOT)) begin : g_mem
            assign slot_val[g] = mem_rdata;
         end else if (g < int'(MEM_SLOT)) begin : g_lo
            assign slot_val[g] = regs_in[g*DW +: DW];
         end else begin : g_hi
            assign slot_val[g] = regs_in[(g-1)*DW +: DW];
         end
      end
   endgenerate

   bitop_decode u_decode (
      .opcode    (opcode),
      .acc_short (acc_short),
      .uop       (live_uop)
   );

   assign alu_uop     = busy ? held_uop : live_uop;
   assign alu_cin     = busy ? held_c : carry_in;
   assign alu_operand = slot_val[alu_uop.slot];

   bitop_alu #(.DW(DW)) u_alu (
      .uop     (alu_uop),
      .operand (alu_operand),
      .cin     (alu_cin),
      .res     (alu_res),
      .flags   (alu_flags)
   );

   bitop_seq #(.DW(DW), .AW(AW)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .live_uop  (live_uop),
      .carry_in  (carry_in),
      .hl        (hl),
      .alu_res   (alu_res),
      .alu_flags (alu_flags),
      .busy      (busy),
      .held_uop  (held_uop),
      .held_c    (held_c),
      .done      (done),
      .out_data  (out_data),
      .reg_we    (reg_we),
      .reg_sel   (reg_sel),
      .flags_we  (flags_we),
      .flags_out (flags_out),
      .mem_rd    (mem_rd),
      .mem_wr    (mem_wr),
      .mem_addr  (mem_addr)
   );

endmodule

// File: rtl/bitop_unit_chk.sv
module bitop_unit_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       done,
   input logic       reg_we,
   input logic [2:0] reg_sel,
   input logic       mem_rd,
   input logic       mem_wr
);

   // R11
   rdwr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));

   // R11
   rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |=> !mem_rd);

   // R11
   rd_to_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |-> ##2 done);

   // R10
   regwe_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |-> (done && !mem_wr));

   // R1
   regsel_nomem_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |-> (reg_sel != 3'd6));

   // R11
   wr_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> done);

endmodule

bind bitop_unit bitop_unit_chk u_bitop_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .done    (done),
   .reg_we  (reg_we),
   .reg_sel (reg_sel),
   .mem_rd  (mem_rd),
   .mem_wr  (mem_wr)
);

// File: tb/test_bitop_unit.sv
module test_bitop_unit;

   localparam int CLK_PERIOD = 10;
   localparam int LIMIT      = 150000;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        start;
   logic [7:0]  opcode;
   logic        acc_short;
   logic [55:0] regs_in;
   logic [15:0] hl;
   logic        carry_in;
   logic [7:0]  mem_rdata;
   logic        busy, done, reg_we, flags_we, mem_rd, mem_wr;
   logic [7:0]  out_data;
   logic [2:0]  reg_sel;
   logic [3:0]  flags_out;
   logic [15:0] mem_addr;

   logic [7:0] mem [256];
   int n_checks = 0;
   int n_err = 0;
   int seed = 7;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign mem_rdata = mem[mem_addr[7:0]];

   bitop_unit i_bitop_unit (
      .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
      .acc_short(acc_short), .regs_in(regs_in), .hl(hl), .carry_in(carry_in),
      .mem_rdata(mem_rdata), .busy(busy), .done(done), .out_data(out_data),
      .reg_we(reg_we), .reg_sel(reg_sel), .flags_we(flags_we),
      .flags_out(flags_out), .mem_rd(mem_rd), .mem_wr(mem_wr),
      .mem_addr(mem_addr)
   );

   function automatic int rnd();
      seed = seed * 1103515245 + 12345;
      return (seed >>> 8) & 255;
   endfunction

   task automatic chk(input string tag, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   // behavioural reference for one operation
   task automatic model(input int op, input bit acc_s, input int v, input int cin,
                        output int res, output int fl, output bit wr, output bit fw);
      int grp, f, m, c, z;
      grp = acc_s ? 0 : (op >> 6) & 3;
      f   = acc_s ? (op >> 3) & 3 : (op >> 3) & 7;
      m   = 1 << f;
      c   = 0;
      res = v;
      fl  = 0;
      case (grp)
         0: begin
            case (f)
               0: begin c = (v >> 7) & 1; res = ((v << 1) | c) & 255; end
               1: begin c = v & 1; res = (v >> 1) | (c << 7); end
               2: begin c = (v >> 7) & 1; res = ((v << 1) | cin) & 255; end
               3: begin c = v & 1; res = (v >> 1) | (cin << 7); end
               4: begin c = (v >> 7) & 1; res = (v << 1) & 255; end
               5: begin c = v & 1; res = (v >> 1) | (v & 128); end
               6: begin c = 0; res = ((v << 4) | (v >> 4)) & 255; end
               default: begin c = v & 1; res = v >> 1; end
            endcase
            z  = (!acc_s && res == 0) ? 1 : 0;
            fl = z * 8 + c;
            wr = 1; fw = 1;
         end
         1: begin
            z  = ((v & m) == 0) ? 1 : 0;
            fl = z * 8 + 2 + cin;
            wr = 0; fw = 1;
         end
         2: begin res = v & ~m & 255; wr = 1; fw = 0; end
         default: begin res = v | m; wr = 1; fw = 0; end
      endcase
   endtask

   function automatic string data_tag(input int op, input bit acc_s);
      int f;
      f = (op >> 3) & 7;
      if (acc_s) return "R9";
      if (((op >> 6) & 3) != 0) return "R2";
      if (f <= 3) return "R5";
      if (f == 6) return "R7";
      return "R6";
   endfunction

   function automatic string flag_tag(input int op, input bit acc_s);
      if (acc_s) return "R9";
      if (((op >> 6) & 3) == 1) return "R3";
      if (((op >> 6) & 3) == 0) return "R8";
      return "R4";
   endfunction

   task automatic run_reg(input int op, input bit acc_s);
      int slot, idx, v, cin, res, fl;
      bit wr, fw;
      slot = acc_s ? 7 : op & 7;
      idx  = (slot < 6) ? slot : 6;
      v    = regs_in[idx*8 +: 8];
      cin  = carry_in;
      model(op, acc_s, v, cin, res, fl, wr, fw);
      @(negedge clk);
      opcode = 8'(op); acc_short = acc_s; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R10", "done", done, 1);
      chk("R10", "reg_we", reg_we, wr);
      if (wr) chk("R1", "reg_sel", reg_sel, slot);
      if (wr) chk(data_tag(op, acc_s), "out_data", out_data, res);
      chk(flag_tag(op, acc_s), "flags_we", flags_we, fw);
      if (fw) chk(flag_tag(op, acc_s), "flags_out", flags_out, fl);
      chk("R11", "mem strobes", {mem_rd, mem_wr}, 0);
      @(negedge clk);
      chk("R10", "done pulse end", {done, reg_we}, 0);
   endtask

   task automatic run_mem(input int op, input int hlv, input bit intrude);
      int v, cin, res, fl;
      bit wr, fw;
      v   = mem[hlv & 255];
      cin = carry_in;
      model(op, 0, v, cin, res, fl, wr, fw);
      @(negedge clk);
      opcode = 8'(op); acc_short = 1'b0; hl = 16'(hlv); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R11", "mem_rd", mem_rd, 1);
      chk("R11", "mem_addr", mem_addr, hlv);
      chk("R11", "done early", done, 0);
      if (intrude) begin
         opcode = 8'h07; start = 1'b1;
      end
      @(negedge clk);
      start = 1'b0;
      opcode = 8'(op);
      chk(intrude ? "R12" : "R11", "exec idle", {mem_rd, mem_wr, done, reg_we}, 0);
      @(negedge clk);
      chk(intrude ? "R12" : "R11", "done", done, 1);
      chk("R11", "mem_wr", mem_wr, wr);
      chk("R11", "reg_we", reg_we, 0);
      if (wr) chk(data_tag(op, 0), "mem data", out_data, res);
      chk(flag_tag(op, 0), "flags_we", flags_we, fw);
      if (fw) chk(flag_tag(op, 0), "flags_out", flags_out, fl);
      if (mem_wr) mem[mem_addr[7:0]] = out_data;
      @(negedge clk);
      chk(intrude ? "R12" : "R11", "after", {done, mem_wr, reg_we, busy}, 0);
   endtask

   initial begin
      bit timeout;
      timeout   = 1'b0;
      rst_n     = 1'b0;
      start     = 1'b0;
      opcode    = '0;
      acc_short = 1'b0;
      regs_in   = '0;
      hl        = '0;
      carry_in  = 1'b0;
      for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 5);
      fork
         begin
            repeat (3) @(negedge clk);
            // R13 reset state
            chk("R13", "reset outputs",
                {done, busy, reg_we, flags_we, mem_rd, mem_wr}, 0);
            rst_n = 1'b1;
            // R5 through-carry with carry set: B=0x80 -> 0x01, C=1
            regs_in = 56'h00_00_00_00_00_00_80;
            carry_in = 1'b1;
            run_reg(8'h10, 0);
            // R6 arithmetic shift keeps sign on C register
            regs_in = 56'h00_00_00_00_00_81_00;
            run_reg(8'h29, 0);
            // R8 zero result sets Z (logical shift of 0x01 in E)
            regs_in = 56'h00_00_00_01_00_00_00;
            run_reg(8'h3B, 0);
            // R9 short form of 0x00 still clears Z, bits 2:0 ignored
            regs_in = 56'h00_00_00_00_00_00_FF;
            run_reg(8'h00, 1);
            run_reg(8'h1B, 1);
            // R3 test on a zero bit keeps C
            regs_in = 56'hEF_00_00_00_00_00_00;
            carry_in = 1'b0;
            run_reg(8'h67, 0);
            // full sweep of the page with varied operands
            for (int op = 0; op < 256; op++) begin
               for (int k = 0; k < 7; k++) regs_in[k*8 +: 8] = 8'(rnd());
               if (op % 5 == 0) regs_in = '0;
               if (op % 7 == 0) regs_in = '1;
               carry_in = rnd() & 1;
               if ((op & 7) == 6) run_mem(op, rnd() | (rnd() << 8), 0);
               else run_reg(op, 0);
            end
            // short accumulator forms
            for (int op = 0; op < 32; op += 8) begin
               for (int k = 0; k < 4; k++) begin
                  regs_in[48 +: 8] = 8'((k == 0) ? 0 : rnd());
                  carry_in = k & 1;
                  run_reg(op | (k & 7), 1);
               end
            end
            // R12 start during memory sequence is dropped
            carry_in = 1'b1;
            run_mem(8'h16, 16'h1234, 1);
            run_mem(8'hFE, 16'h00AA, 1);
            run_mem(8'h46, 16'h00AA, 1);
         end
         begin
            repeat (LIMIT) @(posedge clk);
            timeout = 1'b1;
         end
      join_any
      disable fork;
      if (timeout) begin
         n_checks++;
         n_err++;
         $display("FAIL watchdog: actual timeout expected completion");
      end
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
   end

endmodule